// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block holds six 32-bit event counters and two configuration registers behind a single-cycle register port. The four low counters each take an 8-bit event code from the selector register and count either retired instructions or clock cycles. The fifth counter always counts instructions and the sixth always counts cycles. Freeze bits stop everything at once, the four low counters as a group, or the two fixed counters as a pair.

Each cycle the core drives how many instructions retired (0 to 4) and a run-latch bit. A counter with its condition-enable bit set clamps at the sign threshold 0x80000000 and raises an overflow event. If the interrupt-enable bit is set, that event sets a sticky interrupt request. Software clears the request through a status register.

Each counter slice is driven by a four-valued mode: `CM_IDLE`, `CM_INSN`, `CM_INSN_RUN` (instructions only while the run latch is high) and `CM_CYCLE`. The request logic is a two-state machine. State `IRQ_IDLE` moves to `IRQ_PENDING` on transition *raise*, which is an overflow while interrupts are enabled. `IRQ_PENDING` moves back to `IRQ_IDLE` on transition *ack*, which is a write of 1 to the status bit in a cycle with no enabled overflow. In every other case each state holds.

Top module: `perfmon_bank`

## Requirements
- R1: The register map is: address 0 control word, 1 selector word, 2 to 7 counters one to six, 8 status (bit 0 = interrupt request). Any other address reads zero. After reset the control word reads 0x01, and every other register and the interrupt request read zero.
- R2: Control bit 0 (global freeze) stops every counter from changing, except through software writes.
- R3: Control bit 1 stops counters one to four, and these counters also stay idle while the selector word is zero. Control bit 2 stops counters five and six.
- R4: Counter one takes its code from selector bits 7:0. It adds the retired count for codes 0x02 and 0xFE, adds 1 per clock for codes 0x1E and 0xF0, and is idle for any other code.
- R5: Counters two and three take their codes from selector bits 15:8 and 23:16. Each adds the retired count for code 0x02 and adds 1 per clock for code 0x1E. Any other code leaves it idle.
- R6: Counter four takes its code from selector bits 31:24. It adds the retired count for code 0x02. For code 0xFA it adds the retired count only in cycles where the run latch is high. It adds 1 per clock for code 0x1E.
- R7: Counter five adds the retired count (0 to 4) every clock, and counter six adds 1 every clock, unless they are frozen.
- R8: A counting counter whose sum reaches or passes 0x80000000 is set to exactly 0x80000000 and flags overflow, but only when its enable bit is set. Counter one uses control bit 3, and counters two to six use control bit 4. With the enable bit clear, the sum wraps modulo 2^32.
- R9: An overflow while control bit 5 is set raises the interrupt request on the next clock. The request holds until a write of 1 to status bit 0, which clears it unless an enabled overflow occurs in the same cycle. An overflow while bit 5 is clear leaves the request low.
- R10: A software write to a counter overrides any increment in the same cycle and masks that cycle's overflow. The written value reads back from the next clock.
- R11: Writes to the control and selector words take effect on the clock after the write. Counting during the write cycle follows the previous settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inst_cnt | input | 3 | Instructions retired this cycle (0 to 4) |
| run_latch | input | 1 | Run-latch state, gates code 0xFA on counter four |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Sticky interrupt request |

## Verification
A counter update or an interrupt raise appears at the clock edge that follows the input, so it can be read back half a period later. A control or selector write needs one more edge before it steers counting. The bench drives every input just after a falling edge. Its behavioural model advances on the same rising edge as the design, and read data and the interrupt request are compared at the next falling edge, one cycle after the stimulus. Directed checks on saturation, wrapping, write priority and delayed configuration sample at the exact edge counts worked out from these latencies.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int SEL_W       = 8;
    localparam int C0_FRZ_ALL  = 0;
    localparam int C0_FRZ_LO   = 1;
    localparam int C0_FRZ_HI   = 2;
    localparam int C0_CE_FIRST = 3;
    localparam int C0_CE_REST  = 4;
    localparam int C0_IRQ_EN   = 5;
    localparam int C0_W        = 6;

    typedef enum logic [1:0] {
        CM_IDLE,
        CM_INSN,
        CM_INSN_RUN,
        CM_CYCLE
    } cnt_mode_e;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_PENDING
    } irq_state_e;

    // Event code to counting mode; the first slot and the last slot accept extra codes
    function automatic cnt_mode_e sel_decode(input logic first, input logic last,
                                             input logic [SEL_W-1:0] code);
        cnt_mode_e m;
        m = CM_IDLE;
        if (code == 8'h02)                m = CM_INSN;
        else if (code == 8'h1E)           m = CM_CYCLE;
        else if (first && code == 8'hFE)  m = CM_INSN;
        else if (first && code == 8'hF0)  m = CM_CYCLE;
        else if (last && code == 8'hFA)   m = CM_INSN_RUN;
        return m;
    endfunction

endpackage

// File: rtl/perfmon_decode.sv
module perfmon_decode
    import perfmon_pkg::*;
#(
    parameter int NSEL = 4
) (
    input  logic                  frz_all_i,
    input  logic                  frz_lo_i,
    input  logic                  frz_hi_i,
    input  logic [NSEL*SEL_W-1:0] sel_i,
    output cnt_mode_e             mode_o [NSEL+2]
);

    logic lo_on;
    logic hi_on;

    assign lo_on = !frz_all_i && !frz_lo_i && (sel_i != '0);
    assign hi_on = !frz_all_i && !frz_hi_i;

    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        assign mode_o[i] = lo_on ? sel_decode(i == 0, i == NSEL - 1, sel_i[i*SEL_W +: SEL_W])
                                 : CM_IDLE;
    end

    assign mode_o[NSEL]   = hi_on ? CM_INSN  : CM_IDLE;
    assign mode_o[NSEL+1] = hi_on ? CM_CYCLE : CM_IDLE;

endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter
    import perfmon_pkg::*;
#(
    parameter int CW = 32,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cnt_mode_e     mode_i,
    input  logic          run_i,
    input  logic [IW-1:0] inst_i,
    input  logic          ce_i,
    input  logic          wr_i,
    input  logic [CW-1:0] wr_data_i,
    output logic [CW-1:0] value_o,
    output logic          ovf_o
);

    localparam logic [CW-1:0] THR     = CW'(1) << (CW - 1);
    localparam logic [CW:0]   THR_EXT = {1'b0, THR};

    logic [CW-1:0] value_q;
    logic [CW-1:0] inc;
    logic [CW:0]   sum;
    logic          active;

    always_comb begin
        unique case (mode_i)
            CM_IDLE: begin
                active = 1'b0;
                inc    = '0;
            end
            CM_INSN: begin
                active = 1'b1;
                inc    = CW'(inst_i);
            end
            CM_INSN_RUN: begin
                active = run_i;
                inc    = run_i ? CW'(inst_i) : '0;
            end
            CM_CYCLE: begin
                active = 1'b1;
                inc    = CW'(1);
            end
            default: begin
                active = 1'b0;
                inc    = '0;
            end
        endcase
        sum   = {1'b0, value_q} + {1'b0, inc};
        ovf_o = active && ce_i && !wr_i && (sum >= THR_EXT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        value_q <= '0;
        else if (wr_i)     value_q <= wr_data_i;
        else if (ovf_o)    value_q <= THR;
        else if (active)   value_q <= sum[CW-1:0];
    end

    assign value_o = value_q;

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == CM_IDLE && !wr_i) |=> $stable(value_o)); // R2

    AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (value_o == THR)); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (value_o == $past(wr_data_i))); // R10

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == CM_CYCLE && !wr_i && !ovf_o) |=> (value_o == $past(value_o) + CW'(1))); // R7

endmodule

// File: rtl/perfmon_irq.sv
module perfmon_irq
    import perfmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_any_i,
    input  logic en_i,
    input  logic clr_i,
    output logic irq_o
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic       raise;

    assign raise = ovf_any_i && en_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:    if (raise)           state_d = IRQ_PENDING;
            IRQ_PENDING: if (clr_i && !raise) state_d = IRQ_IDLE;
            default:                          state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_PENDING);
    end

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_any_i && en_i) |=> irq_o); // R9

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_i) |=> irq_o); // R9

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !(ovf_any_i && en_i)) |=> !irq_o); // R9

endmodule

// File: rtl/perfmon_bank.sv
module perfmon_bank
    import perfmon_pkg::*;
#(
    parameter int CW   = 32,
    parameter int IW   = 3,
    parameter int AW   = 4,
    parameter int NSEL = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] inst_cnt,
    input  logic          run_latch,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_data,
    output logic          irq
);

    localparam int NCNT    = NSEL + 2;
    localparam int C1_W    = NSEL * SEL_W;
    localparam int A_CTRL0 = 0;
    localparam int A_CTRL1 = 1;
    localparam int A_CNT0  = 2;
    localparam int A_STAT  = A_CNT0 + NCNT;
    localparam logic [C0_W-1:0] C0_RESET = C0_W'(1) << C0_FRZ_ALL;

    logic [C0_W-1:0] ctrl0_q;
    logic [C1_W-1:0] ctrl1_q;
    cnt_mode_e       mode    [NCNT];
    logic [CW-1:0]   cnt_val [NCNT];
    logic [NCNT-1:0] ovf_vec;
    logic            clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl0_q <= C0_RESET;
            ctrl1_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(A_CTRL0)) ctrl0_q <= wr_data[C0_W-1:0];
            if (wr_addr == AW'(A_CTRL1)) ctrl1_q <= wr_data[C1_W-1:0];
        end
    end

    perfmon_decode #(.NSEL(NSEL)) i_decode (
        .frz_all_i (ctrl0_q[C0_FRZ_ALL]),
        .frz_lo_i  (ctrl0_q[C0_FRZ_LO]),
        .frz_hi_i  (ctrl0_q[C0_FRZ_HI]),
        .sel_i     (ctrl1_q),
        .mode_o    (mode)
    );

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        logic ce;
        if (i == 0) begin : g_first
            assign ce = ctrl0_q[C0_CE_FIRST];
        end else begin : g_rest
            assign ce = ctrl0_q[C0_CE_REST];
        end

        perfmon_counter #(.CW(CW), .IW(IW)) i_counter (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_i    (mode[i]),
            .run_i     (run_latch),
            .inst_i    (inst_cnt),
            .ce_i      (ce),
            .wr_i      (wr_en && (wr_addr == AW'(A_CNT0 + i))),
            .wr_data_i (wr_data),
            .value_o   (cnt_val[i]),
            .ovf_o     (ovf_vec[i])
        );
    end

    assign clr = wr_en && (wr_addr == AW'(A_STAT)) && wr_data[0];

    perfmon_irq i_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf_any_i (|ovf_vec),
        .en_i      (ctrl0_q[C0_IRQ_EN]),
        .clr_i     (clr),
        .irq_o     (irq)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(A_CTRL0))      rd_data = CW'(ctrl0_q);
        else if (rd_addr == AW'(A_CTRL1)) rd_data = CW'(ctrl1_q);
        else if (rd_addr == AW'(A_STAT))  rd_data = CW'(irq);
        else begin
            for (int i = 0; i < NCNT; i++) begin
                if (rd_addr == AW'(A_CNT0 + i)) rd_data = cnt_val[i];
            end
        end
    end

    AST_FREEZE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl0_q[C0_FRZ_ALL] && !wr_en) |=> $stable(cnt_val[NCNT-1])); // R2

    AST_QUIET_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl0_q[C0_FRZ_ALL] |-> (ovf_vec == '0)); // R2

endmodule

// File: tb/test_perfmon_bank.sv
module test_perfmon_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  inst_cnt = '0;
    logic        run_latch = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 0;

    // reference state
    bit [5:0]    m_c0;
    bit [31:0]   m_c1;
    bit [31:0]   m_cnt [6];
    bit          m_irq;

    always #10 clk = ~clk;

    perfmon_bank i_perfmon_bank (
        .clk(clk), .rst_n(rst_n), .inst_cnt(inst_cnt), .run_latch(run_latch),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    // how much counter k advances this cycle under the current settings
    function automatic void mdl_eval(input int k, output bit act, output int unsigned amt);
        bit [7:0] code;
        act = 0;
        amt = 0;
        if (m_c0[0]) return;
        if (k < 4) begin
            if (m_c0[1] || m_c1 == 0) return;
            code = m_c1[8*k +: 8];
            if (code == 8'h02) begin act = 1; amt = inst_cnt; end
            else if (code == 8'h1E) begin act = 1; amt = 1; end
            else if (k == 0 && code == 8'hFE) begin act = 1; amt = inst_cnt; end
            else if (k == 0 && code == 8'hF0) begin act = 1; amt = 1; end
            else if (k == 3 && code == 8'hFA && run_latch) begin act = 1; amt = inst_cnt; end
        end else begin
            if (m_c0[2]) return;
            act = 1;
            amt = (k == 4) ? inst_cnt : 1;
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_c0 = 6'h01;
            m_c1 = 0;
            for (int k = 0; k < 6; k++) m_cnt[k] = 0;
            m_irq = 0;
        end else begin
            bit [31:0] nxt [6];
            bit any_ovf;
            any_ovf = 0;
            for (int k = 0; k < 6; k++) begin
                bit act;
                int unsigned amt;
                longint unsigned s;
                bit ce;
                mdl_eval(k, act, amt);
                nxt[k] = m_cnt[k];
                ce = (k == 0) ? m_c0[3] : m_c0[4];
                s = longint'(m_cnt[k]) + amt;
                if (wr_en && wr_addr == 4'(k + 2)) nxt[k] = wr_data;
                else if (act && ce && s >= 64'h8000_0000) begin
                    nxt[k] = 32'h8000_0000;
                    any_ovf = 1;
                end else if (act) nxt[k] = s[31:0];
            end
            if (any_ovf && m_c0[5]) m_irq = 1;
            else if (wr_en && wr_addr == 4'd8 && wr_data[0]) m_irq = 0;
            for (int k = 0; k < 6; k++) m_cnt[k] = nxt[k];
            if (wr_en && wr_addr == 4'd0) m_c0 = wr_data[5:0];
            if (wr_en && wr_addr == 4'd1) m_c1 = wr_data;
        end
    end

    function automatic bit [31:0] mdl_read(input bit [3:0] a);
        if (a == 0) return {26'd0, m_c0};
        if (a == 1) return m_c1;
        if (a >= 2 && a <= 7) return m_cnt[a - 2];
        if (a == 8) return {31'd0, m_irq};
        return 0;
    endfunction

    task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: wait for the falling edge, compare against the model
    task automatic tick();
        @(negedge clk);
        chk({cur_req, " rd_data"}, rd_data, mdl_read(rd_addr));
        chk({cur_req, " irq"}, {31'd0, irq}, {31'd0, m_irq});
    endtask

    task automatic wr(input bit [3:0] a, input bit [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            rd_addr = (rd_addr == 4'd8) ? 4'd0 : rd_addr + 4'd1;
            tick();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset contents
        cur_req = "R1";
        for (int a = 0; a < 10; a++) begin
            rd_addr = 4'(a);
            tick();
            chk("R1 reset value", rd_data, (a == 0) ? 32'h1 : 32'h0);
        end

        // R7 fixed counters, R3 low counters idle while selector is zero
        cur_req = "R7";
        inst_cnt = 3;
        wr(0, 32'h0);
        run(12);
        cur_req = "R3";
        rd_addr = 2;
        tick();
        chk("R3 selector zero keeps counter one idle", rd_data, 32'h0);

        // R4 counter one codes
        cur_req = "R4";
        foreach (v[i]) begin end
        wr(1, 32'h0000_0002); run(6);
        wr(1, 32'h0000_00FE); run(6);
        wr(1, 32'h0000_001E); run(6);
        wr(1, 32'h0000_00F0); run(6);
        wr(1, 32'h0000_0055); run(6);

        // R5 counters two and three
        cur_req = "R5";
        inst_cnt = 2;
        wr(1, 32'h0002_1E00); run(8);
        wr(1, 32'h001E_0200); run(8);
        wr(1, 32'h0077_FE00); run(8);

        // R6 counter four, run-gated code
        cur_req = "R6";
        wr(1, 32'hFA00_0000);
        rd_addr = 5;
        run_latch = 0; tick(); tick();
        run_latch = 1; tick(); tick();
        run_latch = 0; tick();
        wr(1, 32'h0200_0000); run(5);
        wr(1, 32'h1E00_0000); run(5);

        // R3 group freezes
        cur_req = "R3";
        wr(1, 32'h1E1E_1E1E);
        wr(0, 32'h02); run(9);
        wr(0, 32'h04); run(9);

        // R2 global freeze
        cur_req = "R2";
        wr(0, 32'h01);
        rd_addr = 7; tick(); v = rd_data;
        run(9);
        rd_addr = 7; tick();
        chk("R2 frozen counter six", rd_data, v);

        // R8 saturation on counter one
        cur_req = "R8";
        inst_cnt = 4;
        wr(1, 32'h0000_0002);
        wr(2, 32'h7FFF_FFFE);
        wr(0, 32'h08);
        rd_addr = 2; tick(); tick();
        chk("R8 counter one held at threshold", rd_data, 32'h8000_0000);
        // wrap without enable on counter two
        wr(0, 32'h01);
        wr(3, 32'hFFFF_FFFE);
        wr(1, 32'h0000_1E00);
        wr(0, 32'h00);
        rd_addr = 3; tick(); tick(); tick();
        chk("R8 counter two wraps without enable", rd_data, 32'h0000_0001);
        // cycle counter six with shared enable
        wr(0, 32'h01);
        wr(7, 32'h7FFF_FFFD);
        wr(0, 32'h10);
        rd_addr = 7; run(0); tick(); tick(); tick(); tick();
        chk("R8 counter six clamps", rd_data, 32'h8000_0000);

        // R9 interrupt request
        cur_req = "R9";
        wr(0, 32'h01);
        wr(1, 32'h0000_0002);
        wr(2, 32'h7FFF_FFFF);
        wr(0, 32'h08);
        rd_addr = 8; tick(); tick();
        chk("R9 overflow without enable leaves irq low", {31'd0, irq}, 32'h0);
        wr(0, 32'h28);
        tick();
        chk("R9 irq raised", {31'd0, irq}, 32'h1);
        wr(0, 32'h21); tick(); tick();
        chk("R9 irq sticky", {31'd0, irq}, 32'h1);
        wr(8, 32'h1);
        chk("R9 irq cleared", {31'd0, irq}, 32'h0);

        // R10 write beats increment
        cur_req = "R10";
        wr(0, 32'h00);
        rd_addr = 7;
        wr(7, 32'h0000_0100);
        chk("R10 written value", rd_data, 32'h0000_0100);
        tick();
        chk("R10 counts from written value", rd_data, 32'h0000_0101);

        // R11 control write delay
        cur_req = "R11";
        rd_addr = 7; tick(); v = rd_data;
        wr(0, 32'h01);
        chk("R11 write cycle uses old settings", rd_data, v + 1);
        tick();
        chk("R11 new settings from next clock", rd_data, v + 1);

        // mixed traffic against the model
        cur_req = "R10";
        for (int n = 0; n < 600; n++) begin
            bit [3:0] a;
            inst_cnt = 3'($urandom_range(0, 4));
            run_latch = 1'($urandom);
            rd_addr = 4'($urandom_range(0, 9));
            if ($urandom_range(0, 9) < 3) begin
                a = 4'($urandom_range(0, 8));
                wr_en = 1; wr_addr = a;
                if (a == 1) begin
                    case ($urandom_range(0, 3))
                        0: wr_data = 32'h1E02_1E02;
                        1: wr_data = 32'hFA1E_02F0;
                        2: wr_data = 32'h0202_02FE;
                        default: wr_data = $urandom;
                    endcase
                end else if (a >= 2 && a <= 7)
                    wr_data = ($urandom_range(0, 1) == 1) ? 32'h7FFF_FFF0 + 32'($urandom_range(0, 31)) : $urandom;
                else if (a == 0)
                    wr_data = 32'($urandom_range(0, 63)) & 32'h3E;
                else wr_data = $urandom;
            end else wr_en = 0;
            tick();
        end
        wr_en = 0;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule